// File: doc/BRIEF.md
# CPU Bus Phase Generator and Address Decoder

This block turns a free-running master clock into the CPU bus phase clock, here called `m2`. One CPU bus cycle lasts twelve master cycles. `m2` is low for the first four and a half master cycles and high for the remaining seven and a half, which gives a 5/8 duty cycle. The rising edge of `m2` falls halfway through a master cycle, so the block uses both edges of the master clock. The falling edge of `m2` lines up with a rising master edge and marks the start of the next bus cycle.

Two one-master-cycle strobes mark points inside each bus cycle. The first marks the master cycle in which a new address and direction are placed on the bus. The second marks the final master cycle of the high phase, when read data is captured. The block also gates the upper three CPU address bits with `m2` to form three active-low selects: program ROM, the picture-processor register window, and work RAM. A write-data enable is active while `m2` is high on write cycles.

Top module: `bus_phase_gen`

## Requirements
- R1: While `rst_n` is low, `m2`, `addr_stb`, `data_stb` and `wdata_en` are 0, and `rom_sel_n`, `ppu_en_n` and `ram_sel_n` are 1. After release, the first rising master edge starts bus cycle position 1, so position 0 is the interval between release and that edge.
- R2: Number the master cycles within a bus cycle as positions 0 to 11, and split each position into a first half (master clock high) and a second half (master clock low). `m2` is 1 exactly in the halves whose index 2*position+half is at least 9. This makes it high for 15 of 24 halves, rising on a falling master edge in position 4.
- R3: `m2` falls only on the rising master edge that enters position 0, and the sequence repeats every 12 master cycles.
- R4: `addr_stb` is 1 exactly during position 0, and `data_stb` is 1 exactly during position 11.
- R5: `rom_sel_n` is 0 exactly when `m2` is 1 and address bit 2 of `cpu_addr_hi` (CPU A15) is 1.
- R6: `ppu_en_n` is 0 exactly when `m2` is 1 and `cpu_addr_hi` equals 3'b001.
- R7: `ram_sel_n` is 0 exactly when `m2` is 1 and `cpu_addr_hi` equals 3'b000.
- R8: When `cpu_addr_hi` is 3'b010 or 3'b011, all three selects stay 1, and at no time is more than one select 0.
- R9: `wdata_en` is 1 exactly when `m2` is 1 and `cpu_rd_wr_n` is 0 (0 means write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_master | input | 1 | Master clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr_hi | input | 3 | CPU address bits 15..13 (bit 2 = A15) |
| cpu_rd_wr_n | input | 1 | Bus direction, 1 = read, 0 = write |
| m2 | output | 1 | CPU bus phase clock, 5/8 high |
| addr_stb | output | 1 | High during the first master cycle of a bus cycle |
| data_stb | output | 1 | High during the last master cycle of a bus cycle |
| rom_sel_n | output | 1 | Active-low program ROM select |
| ppu_en_n | output | 1 | Active-low picture-processor register enable |
| ram_sel_n | output | 1 | Active-low work-RAM select |
| wdata_en | output | 1 | Write data drive enable during the high phase |

## Verification
The decode assertions assume that `cpu_addr_hi` and `cpu_rd_wr_n` are settled at each rising master edge. The stimulus meets this by changing those inputs only mid-way through the clock-high half. The edge assertions assume the master clock runs without pauses, and the bench keeps it free-running throughout. The stimulus walks every address code in both directions across many bus cycles. It also asserts reset in the middle of a bus cycle, which checks that the phase restarts cleanly.

// File: rtl/busphase_pkg.sv
package busphase_pkg;

  localparam int ADDR_HI_W = 3;

  // internal active-high select vector
  typedef struct packed {
    logic rom;
    logic ppu;
    logic ram;
  } region_t;

  // region hit from the upper CPU address bits (bit 2 = A15)
  function automatic region_t region_hit(input logic [ADDR_HI_W-1:0] a);
    region_t r;
    r.rom = a[2];
    r.ppu = (a == 3'b001);
    r.ram = (a == 3'b000);
    return r;
  endfunction

  // wrap-around step of the bus-cycle position counter
  function automatic int unsigned next_pos(input int unsigned pos, input int unsigned len);
    return (pos == len - 1) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int CYC_LEN  = 12,
  parameter int RISE_IDX = 4,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] pos,
  output logic          hi_part,
  output logic          addr_stb,
  output logic          data_stb
);
  import busphase_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(CYC_LEN - 1);
  localparam logic [CW-1:0] RISE = CW'(RISE_IDX);

  logic [CW-1:0] pos_nxt;
  assign pos_nxt = CW'(next_pos(int'(pos), CYC_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      hi_part <= 1'b0;
    end else begin
      pos     <= pos_nxt;
      hi_part <= (pos_nxt >= RISE);
    end
  end

  assign addr_stb = rst_n & (pos == '0);
  assign data_stb = rst_n & (pos == LAST);

  // R3
  pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == LAST) |=> (pos == '0));

  // R3
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != LAST) |=> (pos == $past(pos) + 1'b1));

endmodule

// File: rtl/m2_shaper.sv
module m2_shaper #(
  parameter bit HALF_EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_part,
  output logic m2
);

  generate
    if (HALF_EDGE) begin : g_half
      logic hi_late;
      // falling-edge copy delays only the rise by half a master cycle
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) hi_late <= 1'b0;
        else        hi_late <= hi_part;
      end
      // only one input toggles at any clock edge, so the AND is glitch-free
      assign m2 = hi_part & hi_late;
    end else begin : g_whole
      assign m2 = hi_part;
    end
  endgenerate

endmodule

// File: rtl/select_decode.sv
module select_decode
  import busphase_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 m2,
  input  logic [ADDR_HI_W-1:0] addr_hi,
  input  logic                 rd_wr_n,
  output logic                 rom_sel_n,
  output logic                 ppu_en_n,
  output logic                 ram_sel_n,
  output logic                 wdata_en
);

  region_t hit;
  logic    qual;

  assign hit  = region_hit(addr_hi);
  assign qual = m2 & rst_n;

  assign rom_sel_n = ~(qual & hit.rom);
  assign ppu_en_n  = ~(qual & hit.ppu);
  assign ram_sel_n = ~(qual & hit.ram);
  assign wdata_en  = qual & ~rd_wr_n;

  // R8
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~rom_sel_n, ~ppu_en_n, ~ram_sel_n}));

  // R5 R6 R7
  low_phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m2 |-> (rom_sel_n && ppu_en_n && ram_sel_n && !wdata_en));

  // R8
  gap_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hi[2:1] == 2'b01) |-> (rom_sel_n && ppu_en_n && ram_sel_n));

  // R9
  wdata_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_en |-> (m2 && !rd_wr_n));

endmodule

// File: rtl/bus_phase_gen.sv
module bus_phase_gen #(
  parameter int CYC_LEN    = 12,
  parameter int LOW_HALVES = 9
) (
  input  logic       clk_master,
  input  logic       rst_n,
  input  logic [2:0] cpu_addr_hi,
  input  logic       cpu_rd_wr_n,
  output logic       m2,
  output logic       addr_stb,
  output logic       data_stb,
  output logic       rom_sel_n,
  output logic       ppu_en_n,
  output logic       ram_sel_n,
  output logic       wdata_en
);

  localparam int CW       = $clog2(CYC_LEN);
  localparam int RISE_IDX = LOW_HALVES / 2;
  localparam bit HALF_EDG = (LOW_HALVES % 2) == 1;

  logic [CW-1:0] pos;
  logic          hi_part;

  phase_counter #(.CYC_LEN(CYC_LEN), .RISE_IDX(RISE_IDX), .CW(CW)) u_cnt (
    .clk      (clk_master),
    .rst_n    (rst_n),
    .pos      (pos),
    .hi_part  (hi_part),
    .addr_stb (addr_stb),
    .data_stb (data_stb)
  );

  m2_shaper #(.HALF_EDGE(HALF_EDG)) u_m2 (
    .clk     (clk_master),
    .rst_n   (rst_n),
    .hi_part (hi_part),
    .m2      (m2)
  );

  select_decode u_dec (
    .clk       (clk_master),
    .rst_n     (rst_n),
    .m2        (m2),
    .addr_hi   (cpu_addr_hi),
    .rd_wr_n   (cpu_rd_wr_n),
    .rom_sel_n (rom_sel_n),
    .ppu_en_n  (ppu_en_n),
    .ram_sel_n (ram_sel_n),
    .wdata_en  (wdata_en)
  );

  // R3
  m2_fall_chk: assert property (@(posedge clk_master) disable iff (!rst_n)
    $fell(m2) |-> (pos == '0));

  // R2
  m2_rise_chk: assert property (@(posedge clk_master) disable iff (!rst_n)
    $rose(m2) |-> (pos == CW'(RISE_IDX)));

  // R4
  stb_excl_chk: assert property (@(posedge clk_master) disable iff (!rst_n)
    !(addr_stb && data_stb));

endmodule

// File: tb/bus_phase_gen_tb.sv
module bus_phase_gen_tb;

  localparam int CLK_P      = 10;
  localparam int CYC        = 12;
  localparam int LOW_H      = 9;
  localparam int HIGH_HALFS = 2 * CYC - LOW_H;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr;
  logic       rw_n;
  logic       m2, addr_stb, data_stb, rom_sel_n, ppu_en_n, ram_sel_n, wdata_en;

  int nchk = 0, nfail = 0;
  int k = 0;
  int hcount = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_phase_gen u_dut (
    .clk_master  (clk),
    .rst_n       (rst_n),
    .cpu_addr_hi (addr),
    .cpu_rd_wr_n (rw_n),
    .m2          (m2),
    .addr_stb    (addr_stb),
    .data_stb    (data_stb),
    .rom_sel_n   (rom_sel_n),
    .ppu_en_n    (ppu_en_n),
    .ram_sel_n   (ram_sel_n),
    .wdata_en    (wdata_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d (k=%0d t=%0t)", tag, act, exp, k, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  // R1: everything idle while reset is held
  task automatic check_reset();
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); rw_n = a[0];
      #1;
      check("R1 m2", m2, 0);
      check("R1 addr_stb", addr_stb, 0);
      check("R1 data_stb", data_stb, 0);
      check("R1 selects", {rom_sel_n, ppu_en_n, ram_sel_n}, 3'b111);
      check("R1 wdata_en", wdata_en, 0);
    end
  endtask

  // compare against the half-cycle reference; second=1 for the clock-low half
  task automatic sample(input bit second);
    int p, h;
    bit em2;
    p   = k % CYC;
    h   = 2 * p + (second ? 1 : 0);
    em2 = (h >= LOW_H);
    if (!second && p == 0) begin
      if (k >= CYC) check("R2 high halves per cycle", hcount, HIGH_HALFS);
      hcount = 0;
    end
    if (m2) hcount++;
    check(p == 0 ? "R3 m2 at cycle start" : "R2 m2 level", m2, em2);
    check("R4 addr_stb", addr_stb, p == 0);
    check("R4 data_stb", data_stb, p == CYC - 1);
    check("R5 rom_sel_n", rom_sel_n, !(em2 && addr[2]));
    check("R6 ppu_en_n", ppu_en_n, !(em2 && addr == 3'b001));
    check("R7 ram_sel_n", ram_sel_n, !(em2 && addr == 3'b000));
    check("R9 wdata_en", wdata_en, em2 && !rw_n);
    if (addr[2:1] == 2'b01)
      check("R8 gap region idle", {rom_sel_n, ppu_en_n, ram_sel_n}, 3'b111);
    check("R8 at most one select", $countones({~rom_sel_n, ~ppu_en_n, ~ram_sel_n}) <= 1, 1);
  endtask

  task automatic run(input int n, input int salt);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      k++;
      #2 sample(1'b0);
      #1;
      addr = 3'((k * 5 + k / 7 + salt) % 8);
      rw_n = ((k / 3) % 2) == 0;
      @(negedge clk);
      #2 sample(1'b1);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    nfail++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; addr = 3'b000; rw_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset();
    @(negedge clk);
    rst_n = 1'b1; k = 0;
    #2 sample(1'b1);
    run(720, 0);
    // reset again in the middle of a bus cycle
    repeat (5) @(posedge clk);
    #3 rst_n = 1'b0;
    check_reset();
    @(negedge clk);
    rst_n = 1'b1; k = 0;
    #2 sample(1'b1);
    run(300, 3);
    summary();
  end

endmodule